// File: doc/BRIEF.md
# Strobe-Timed Two-Register Bus Slave

This block is a slave on a synchronous microcontroller bus with a 16-bit address and a 16-bit data path. A strobe clock E times each bus cycle, and a direction line marks the cycle as a read (line high, data flows to the master) or a write (line low, data flows from the master). The slave answers only inside a two-byte window at 0x4000..0x4001. It holds one 8-bit register at the even address and one at the odd address, and it shows both registers at all times on two parallel 8-bit output ports.

All bus inputs are sampled by a fast local clock through a two-stage synchronizer. A small state machine follows the synchronized E. Its states are `ST_LOW` (E low, nothing pending), `ST_HIGH` (E high, bus fields are being snapshotted) and `ST_COMMIT` (a one-cycle write pulse). Its transitions are:
- `ST_LOW`→`ST_HIGH` when E is seen high.
- `ST_HIGH`→`ST_COMMIT` when E is seen low and the snapshot holds a write that hits the window with a valid lane code.
- `ST_HIGH`→`ST_LOW` when E is seen low in any other case.
- `ST_COMMIT`→`ST_HIGH` or `ST_COMMIT`→`ST_LOW`, depending on the level of E.

Write data is the last value seen while E was high, so data that changes together with the falling edge is not used. For a read, the block raises a separate output-enable that stands in for tri-state control, and it drives the selected byte lanes.

Top module: `ebus_periph_slave`

## Requirements
- R1: After reset, both registers read 0x00 on the output ports, and the read enable is low.
- R2: A write with address bit 0 = 0 and the low-byte strobe low (code 00) to 0x4000 loads the even register from data[15:8] and the odd register from data[7:0].
- R3: A write with address bit 0 = 0 and the strobe high (code 01) loads only the even register from data[15:8]. The odd register is unchanged.
- R4: A write with address bit 0 = 1 and the strobe low (code 10) loads only the odd register from data[7:0]. The even register is unchanged.
- R5: The code with address bit 0 = 1 and the strobe high (code 11) is ignored. It writes neither register and never raises the read enable.
- R6: An address outside 0x4000..0x4001 writes nothing and never raises the read enable.
- R7: A write takes effect only after E falls, and it uses the data seen while E was high. Registers do not change while E is still high, and data that changes at the falling edge is not stored.
- R8: During a read that hits the window with a valid code, while E is high, the read enable is high. The even register appears on data[15:8] if the even lane is selected, the odd register appears on data[7:0] if the odd lane is selected, and an unselected lane reads zero.
- R9: The read enable is low during write cycles and whenever E is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| e_clk | input | 1 | Bus strobe clock E |
| rw_n | input | 1 | High = read, low = write |
| addr | input | 16 | Bus address |
| low_strb_n | input | 1 | Low-byte strobe, combined with addr[0] to pick lanes |
| wdata | input | 16 | Data from the master |
| rdata_out | output | 16 | Data to the master |
| rdata_oe | output | 1 | Drive enable for rdata_out |
| reg_even_q | output | 8 | Register at the even address |
| reg_odd_q | output | 8 | Register at the odd address |

## Verification
The bench sweeps every lane code and both directions across addresses just inside, just outside and far from the window, and tracks expected register contents arithmetically. A decoder that matched only part of the address would let 0x4002 or 0x3FFF through. A swapped lane table would load the wrong byte or both bytes. Each write changes the data bus in the same instant that E falls and checks the registers while E is still high, so a design that latched at the wrong edge or used the data after the edge stores the inverted pattern. Reads under every code check that unselected lanes come back zero and that the reserved code never drives the bus.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

    typedef enum logic [1:0] {
        ST_LOW    = 2'd0,
        ST_HIGH   = 2'd1,
        ST_COMMIT = 2'd2
    } bus_state_t;

    typedef struct packed {
        logic even;
        logic odd;
    } lane_sel_t;

endpackage

// File: rtl/ebus_sync.sv
module ebus_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/ebus_lane_decode.sv
module ebus_lane_decode
    import ebus_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              strb_n,
    output logic              hit,
    output lane_sel_t         lanes
);
    always_comb begin
        hit = (addr[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]);
        unique case ({addr[0], strb_n})
            2'b00:   lanes = '{even: 1'b1, odd: 1'b1};
            2'b01:   lanes = '{even: 1'b1, odd: 1'b0};
            2'b10:   lanes = '{even: 1'b0, odd: 1'b1};
            default: lanes = '{even: 1'b0, odd: 1'b0};
        endcase
    end
endmodule

// File: rtl/ebus_regfile.sv
module ebus_regfile #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        we,
    input  logic [2*BYTE_W-1:0] wd,
    output logic [2*BYTE_W-1:0] q
);
    for (genvar g = 0; g < 2; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[g*BYTE_W +: BYTE_W] <= '0;
            else if (we[g])
                q[g*BYTE_W +: BYTE_W] <= wd[g*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/ebus_periph_slave.sv
module ebus_periph_slave
    import ebus_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              e_clk,
    input  logic              rw_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              low_strb_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata_out,
    output logic              rdata_oe,
    output logic [DATA_W/2-1:0] reg_even_q,
    output logic [DATA_W/2-1:0] reg_odd_q
);
    localparam int BYTE_W = DATA_W / 2;
    localparam int SYNC_W = ADDR_W + DATA_W + 3;

    logic [SYNC_W-1:0] bus_raw, bus_s;
    logic              e_s, rw_s, strb_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;

    assign bus_raw = {e_clk, rw_n, low_strb_n, addr, wdata};
    assign {e_s, rw_s, strb_s, addr_s, data_s} = bus_s;

    ebus_sync #(.W(SYNC_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(bus_raw), .q(bus_s)
    );

    logic      hit_s;
    lane_sel_t lanes_s;

    ebus_lane_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .addr(addr_s), .strb_n(strb_s), .hit(hit_s), .lanes(lanes_s)
    );

    // Snapshot of the bus taken on every cycle that E is seen high
    logic              snap_rw, snap_hit;
    lane_sel_t         snap_lanes;
    logic [DATA_W-1:0] snap_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_rw    <= 1'b1;
            snap_hit   <= 1'b0;
            snap_lanes <= '0;
            snap_data  <= '0;
        end else if (e_s) begin
            snap_rw    <= rw_s;
            snap_hit   <= hit_s;
            snap_lanes <= lanes_s;
            snap_data  <= data_s;
        end
    end

    bus_state_t state_q, state_d;
    logic       snap_write_ok;

    assign snap_write_ok = !snap_rw && snap_hit && (snap_lanes.even || snap_lanes.odd);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOW:    if (e_s) state_d = ST_HIGH;
            ST_HIGH:   if (!e_s) state_d = snap_write_ok ? ST_COMMIT : ST_LOW;
            ST_COMMIT: state_d = e_s ? ST_HIGH : ST_LOW;
            default:   state_d = ST_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOW;
        else        state_q <= state_d;
    end

    logic        we_even, we_odd;
    logic [DATA_W-1:0] regs_q;

    always_comb begin
        we_even   = 1'b0;
        we_odd    = 1'b0;
        rdata_oe  = 1'b0;
        rdata_out = '0;
        unique case (state_q)
            ST_COMMIT: begin
                we_even = snap_lanes.even;
                we_odd  = snap_lanes.odd;
            end
            ST_HIGH: begin
                rdata_oe = e_s && rw_s && hit_s && (lanes_s.even || lanes_s.odd);
                if (rdata_oe) begin
                    if (lanes_s.even) rdata_out[DATA_W-1:BYTE_W] = regs_q[DATA_W-1:BYTE_W];
                    if (lanes_s.odd)  rdata_out[BYTE_W-1:0]      = regs_q[BYTE_W-1:0];
                end
            end
            default: ;
        endcase
    end

    ebus_regfile #(.BYTE_W(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .we({we_even, we_odd}), .wd(snap_data), .q(regs_q)
    );

    assign reg_even_q = regs_q[DATA_W-1:BYTE_W];
    assign reg_odd_q  = regs_q[BYTE_W-1:0];
endmodule

// File: rtl/ebus_periph_slave_chk.sv
module ebus_periph_slave_chk #(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4000
) (
    input logic                clk,
    input logic                rst_n,
    input logic                e_clk,
    input logic                rw_n,
    input logic [ADDR_W-1:0]   addr,
    input logic                low_strb_n,
    input logic [DATA_W-1:0]   rdata_out,
    input logic                rdata_oe,
    input logic [DATA_W/2-1:0] reg_even_q,
    input logic [DATA_W/2-1:0] reg_odd_q,
    input logic                we_even,
    input logic                we_odd
);
    localparam int BYTE_W = DATA_W / 2;

    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (reg_even_q == '0 && reg_odd_q == '0 && !rdata_oe));

    assert_reserved_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> !($past(addr[0], 2) && $past(low_strb_n, 2)));

    assert_window_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> ($past(addr[ADDR_W-1:1], 2) == BASE_ADDR[ADDR_W-1:1]));

    assert_even_needs_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reg_even_q) |-> $past(we_even));

    assert_odd_needs_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reg_odd_q) |-> $past(we_odd));

    assert_even_lane_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata_oe && !$past(addr[0], 2) && $past(low_strb_n, 2)) |-> (rdata_out[BYTE_W-1:0] == '0));

    assert_oe_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> ($past(e_clk, 2) && $past(rw_n, 2)));

    assert_no_write_while_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> !(we_even || we_odd));
endmodule

bind ebus_periph_slave ebus_periph_slave_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .e_clk(e_clk), .rw_n(rw_n), .addr(addr),
    .low_strb_n(low_strb_n), .rdata_out(rdata_out), .rdata_oe(rdata_oe),
    .reg_even_q(reg_even_q), .reg_odd_q(reg_odd_q),
    .we_even(we_even), .we_odd(we_odd)
);

// File: tb/ebus_periph_slave_tb_top.sv
module ebus_periph_slave_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        e_clk = 1'b0;
    logic        rw_n = 1'b1;
    logic [15:0] addr = '0;
    logic        low_strb_n = 1'b1;
    logic [15:0] wdata = '0;
    logic [15:0] rdata_out;
    logic        rdata_oe;
    logic [7:0]  reg_even_q, reg_odd_q;

    int checks = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [7:0] m_even = 8'h00;
    logic [7:0] m_odd  = 8'h00;

    always #2.5 clk = ~clk;

    ebus_periph_slave dut_i (
        .clk(clk), .rst_n(rst_n), .e_clk(e_clk), .rw_n(rw_n), .addr(addr),
        .low_strb_n(low_strb_n), .wdata(wdata), .rdata_out(rdata_out),
        .rdata_oe(rdata_oe), .reg_even_q(reg_even_q), .reg_odd_q(reg_odd_q)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_cycle(input logic [15:0] a, input logic rd, input logic sn,
                             input logic [15:0] wd, input int idx);
        logic hit, ev, od, valid;
        string wtag;
        hit   = (a[15:1] == 15'h2000);
        ev    = !a[0];
        od    = !(a[0] ^ ~sn) ? 1'b0 : 1'b0;
        case ({a[0], sn})
            2'b00: begin ev = 1; od = 1; wtag = "R2"; end
            2'b01: begin ev = 1; od = 0; wtag = "R3"; end
            2'b10: begin ev = 0; od = 1; wtag = "R4"; end
            default: begin ev = 0; od = 0; wtag = "R5"; end
        endcase
        if (!hit) wtag = "R6";
        valid = hit && (ev || od);
        @(negedge clk);
        e_clk = 1'b0; addr = a; rw_n = rd; low_strb_n = sn; wdata = wd;
        repeat (4) @(negedge clk);
        check("R9", "oe while E low", {15'd0, rdata_oe}, 16'd0);
        e_clk = 1'b1;
        repeat (6) @(negedge clk);
        if (rd) begin
            check(valid ? "R8" : wtag, "read oe", {15'd0, rdata_oe}, {15'd0, valid});
            if (valid)
                check("R8", "read data", rdata_out,
                      {ev ? m_even : 8'h00, od ? m_odd : 8'h00});
        end else begin
            check("R9", "oe in write", {15'd0, rdata_oe}, 16'd0);
            check("R7", "regs steady while E high", {reg_even_q, reg_odd_q}, {m_even, m_odd});
        end
        e_clk = 1'b0; wdata = ~wd;
        repeat (6) @(negedge clk);
        if (!rd && valid) begin
            if (ev) m_even = wd[15:8];
            if (od) m_odd  = wd[7:0];
        end
        check(rd ? "R8" : wtag, $sformatf("regs after cycle %0d", idx),
              {reg_even_q, reg_odd_q}, {m_even, m_odd});
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", "reset regs", {reg_even_q, reg_odd_q}, 16'h0000);
        check("R1", "reset oe", {15'd0, rdata_oe}, 16'd0);
        for (int pass = 0; pass < 2; pass++) begin
            for (int ai = 0; ai < 6; ai++) begin
                for (int code = 0; code < 4; code++) begin
                    for (int rd = 0; rd < 2; rd++) begin
                        logic [15:0] a;
                        int idx;
                        idx = ((pass * 6 + ai) * 4 + code) * 2 + rd;
                        case (ai)
                            0: a = 16'h4000;
                            1: a = 16'h3FFE;
                            2: a = 16'h4002;
                            3: a = 16'hC000;
                            4: a = 16'h4100;
                            default: a = 16'h0000;
                        endcase
                        a[0] = code[1];
                        bus_cycle(a, rd[0], code[0],
                                  {8'((idx * 37 + 5) & 255), 8'((idx * 91 + 3) & 255)}, idx);
                    end
                end
            end
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog R7 actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule